// File: doc/BRIEF.md
# Dual-Channel Oversampling Sample Buffer

This block gathers converter results for two analog channels over one bus cycle and presents them as one packet during the following cycle. Each fast sync pulse asks an external converter for a conversion through a start pulse. The converter answers with one result strobe that carries a 16-bit word for each channel. Because both words arrive on the same strobe, the two channels are always sampled at the same instant. No other sampling mode exists.

Results are stored in arrival order in the write half of a two-bank buffer. Each bank holds up to `MAX_N` (default 100) entries per channel. A slow sync pulse closes the cycle: the banks trade roles, and the finished packet of `n_cfg` samples per channel becomes readable through an indexed read port. The next cycle then fills the other bank. If a cycle ends short of `n_cfg` results, the missing entries read as zero. A fast pulse that lands while a conversion is still pending is dropped.

Neither edge of the block has back-pressure. Result strobes are always accepted, so there is no ready signal. A read request is answered exactly one clock later, so that the requester never waits.

Top module: `dual_os_buffer`

## Requirements
- R1: After reset, `conv_start`, `pkt_valid`, `overrun` and `underrun` are all 0. A read returns `rd_data` = 0.
- R2: If `fast_sync` is high while no conversion is pending, `conv_start` is high for exactly one cycle on the next clock. From then on, a conversion is pending until `res_valid` is seen.
- R3: If `fast_sync` is high while a conversion is pending, it starts nothing. It also sets `overrun`, which stays high until reset.
- R4: Each `res_valid` that ends a pending conversion stores `res_a` and `res_b` together at the next free index of the write bank. The k-th result of a cycle lands at index k-1.
- R5: Results past the first `n_cfg` in a cycle are discarded. A `res_valid` with no conversion pending is ignored.
- R6: One clock after `slow_sync`, `pkt_valid` is 1 and stays 1. The packet of the cycle just closed becomes the one that is read.
- R7: If a cycle closes with fewer than `n_cfg` stored results, the missing indices read as 0. `underrun` is then set and stays high until reset.
- R8: A `rd_req` with `rd_ch` (0 = channel A, 1 = channel B) and `rd_idx` gives `rd_valid` = 1 and `rd_data` on the next clock. The data is 0 when `rd_idx` is at or above the packet's fill count, or when no packet exists yet.
- R9: A readable packet keeps its contents while the other bank fills with the next cycle's results.
- R10: Packet length `n_cfg` may be any value from 1 to `MAX_N`, and both limits work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| n_cfg | input | 7 | Samples per packet, 1..MAX_N |
| fast_sync | input | 1 | Sampling pulse |
| slow_sync | input | 1 | Bus-cycle pulse; closes the packet |
| conv_start | output | 1 | Conversion request pulse to the converter |
| res_valid | input | 1 | Converter result strobe |
| res_a | input | 16 | Channel A result |
| res_b | input | 16 | Channel B result |
| rd_req | input | 1 | Read request |
| rd_ch | input | 1 | Read channel select |
| rd_idx | input | 7 | Read sample index |
| rd_valid | output | 1 | Read data valid, one clock after rd_req |
| rd_data | output | 16 | Read data |
| pkt_valid | output | 1 | A complete packet is readable |
| overrun | output | 1 | Sticky: fast pulse while busy |
| underrun | output | 1 | Sticky: short packet |

## Verification
The assertions assume the converter behaves correctly: it raises `res_valid` only for a conversion it was asked for, and once per request. They also assume that `fast_sync` and `slow_sync` are single-cycle pulses and that `n_cfg` stays constant and inside 1..MAX_N for the whole cycle. The bench plays the converter itself. It answers each `conv_start` with exactly one result after a short delay and changes `n_cfg` only while reset is held. The single exception is a deliberate stray result strobe, which tests the ignore rule.

// File: rtl/osb_pkg.sv
package osb_pkg;
  localparam int SAMPLE_W = 16;
  localparam int NUM_CH   = 2;
  typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/osb_conv_ctrl.sv
module osb_conv_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_sync,
  input  logic res_valid,
  output logic conv_start,
  output logic accept,
  output logic overrun
);
  logic busy;

  assign accept = res_valid & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      conv_start <= fast_sync & ~busy;
      if (fast_sync & busy) overrun <= 1'b1;
      if (fast_sync & ~busy)  busy <= 1'b1;
      else if (accept)        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/osb_frame_ctrl.sv
module osb_frame_ctrl #(
  parameter int MAX_N = 100,
  parameter int CNT_W = $clog2(MAX_N + 1),
  parameter int IDX_W = $clog2(MAX_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_sync,
  input  logic             accept,
  input  logic [CNT_W-1:0] n_cfg,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_bank,
  output logic [CNT_W-1:0] rd_fill,
  output logic             pkt_valid,
  output logic             underrun
);
  logic [CNT_W-1:0] wr_cnt;
  logic [CNT_W-1:0] fill_now;

  assign wr_en    = accept && (wr_cnt < n_cfg);
  assign wr_idx   = IDX_W'(wr_cnt);
  assign fill_now = wr_cnt + CNT_W'(wr_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt    <= '0;
      wr_bank   <= 1'b0;
      rd_fill   <= '0;
      pkt_valid <= 1'b0;
      underrun  <= 1'b0;
    end else if (slow_sync) begin
      wr_cnt    <= '0;
      wr_bank   <= ~wr_bank;
      rd_fill   <= fill_now;
      pkt_valid <= 1'b1;
      if (fill_now < n_cfg) underrun <= 1'b1;
    end else if (wr_en) begin
      wr_cnt <= wr_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/osb_chan_mem.sv
module osb_chan_mem #(
  parameter int DW    = 16,
  parameter int MAX_N = 100,
  parameter int IDX_W = $clog2(MAX_N)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             wbank,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic             rbank,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [2][MAX_N];

  always_ff @(posedge clk) begin
    if (we && (int'(widx) < MAX_N)) mem[wbank][widx] <= wdata;
    if (re) begin
      if (int'(ridx) < MAX_N) rdata <= mem[rbank][ridx];
      else                    rdata <= '0;
    end
  end
endmodule

// File: rtl/dual_os_buffer.sv
module dual_os_buffer
  import osb_pkg::*;
#(
  parameter int MAX_N = 100,
  localparam int CNT_W = $clog2(MAX_N + 1),
  localparam int IDX_W = $clog2(MAX_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] n_cfg,
  input  logic             fast_sync,
  input  logic             slow_sync,
  output logic             conv_start,
  input  logic             res_valid,
  input  logic [15:0]      res_a,
  input  logic [15:0]      res_b,
  input  logic             rd_req,
  input  logic             rd_ch,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [15:0]      rd_data,
  output logic             pkt_valid,
  output logic             overrun,
  output logic             underrun
);
  logic             accept;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_bank;
  logic [CNT_W-1:0] rd_fill;
  sample_t          wdata [NUM_CH];
  sample_t          rdata [NUM_CH];
  logic             mask_q;
  logic             ch_q;

  assign wdata[0] = res_a;
  assign wdata[1] = res_b;

  osb_conv_ctrl u_conv (
    .clk(clk), .rst_n(rst_n), .fast_sync(fast_sync), .res_valid(res_valid),
    .conv_start(conv_start), .accept(accept), .overrun(overrun)
  );

  osb_frame_ctrl #(.MAX_N(MAX_N), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .slow_sync(slow_sync), .accept(accept),
    .n_cfg(n_cfg), .wr_en(wr_en), .wr_idx(wr_idx), .wr_bank(wr_bank),
    .rd_fill(rd_fill), .pkt_valid(pkt_valid), .underrun(underrun)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    osb_chan_mem #(.DW(SAMPLE_W), .MAX_N(MAX_N), .IDX_W(IDX_W)) u_mem (
      .clk(clk), .we(wr_en), .wbank(wr_bank), .widx(wr_idx), .wdata(wdata[c]),
      .re(rd_req), .rbank(~wr_bank), .ridx(rd_idx), .rdata(rdata[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      mask_q   <= 1'b0;
      ch_q     <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        ch_q   <= rd_ch;
        mask_q <= pkt_valid && ((CNT_W + 1)'(rd_idx) < (CNT_W + 1)'(rd_fill));
      end
    end
  end

  assign rd_data = mask_q ? (ch_q ? rdata[1] : rdata[0]) : '0;
endmodule

// File: rtl/osb_checker.sv
module osb_checker (
  input logic clk,
  input logic rst_n,
  input logic fast_sync,
  input logic slow_sync,
  input logic conv_start,
  input logic rd_req,
  input logic rd_valid,
  input logic pkt_valid,
  input logic overrun,
  input logic underrun
);
  AST_START_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R2
  AST_START_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(fast_sync)); // R2
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R3
  AST_PKT_AFTER_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    slow_sync |=> pkt_valid); // R6
  AST_PKT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> pkt_valid); // R6
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun); // R7
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R8
  AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid); // R8
endmodule

bind dual_os_buffer osb_checker u_osb_checker (
  .clk(clk), .rst_n(rst_n), .fast_sync(fast_sync), .slow_sync(slow_sync),
  .conv_start(conv_start), .rd_req(rd_req), .rd_valid(rd_valid),
  .pkt_valid(pkt_valid), .overrun(overrun), .underrun(underrun)
);

// File: tb/dual_os_buffer_bench.sv
`timescale 1ns/1ps
module dual_os_buffer_bench;
  localparam int MAX_N = 100;
  localparam int NV = 5;
  localparam logic [6:0]  VN [NV] = '{7'd4, 7'd3, 7'd10, 7'd1, 7'd100};
  localparam logic [6:0]  VP [NV] = '{7'd4, 7'd2, 7'd12, 7'd1, 7'd100};
  localparam logic [15:0] VB [NV] = '{16'h1000, 16'h2200, 16'h7FF0, 16'hFFFF, 16'h0040};

  logic clk = 0, rst_n = 0;
  logic [6:0] n_cfg = 7'd4;
  logic fast_sync = 0, slow_sync = 0, res_valid = 0, rd_req = 0, rd_ch = 0;
  logic [15:0] res_a = 0, res_b = 0;
  logic [6:0] rd_idx = 0;
  logic conv_start, rd_valid, pkt_valid, overrun, underrun;
  logic [15:0] rd_data;
  int checks = 0, errors = 0;
  logic [15:0] got;

  always #2.5 clk = ~clk;

  dual_os_buffer u_dual_os_buffer (
    .clk(clk), .rst_n(rst_n), .n_cfg(n_cfg), .fast_sync(fast_sync),
    .slow_sync(slow_sync), .conv_start(conv_start), .res_valid(res_valid),
    .res_a(res_a), .res_b(res_b), .rd_req(rd_req), .rd_ch(rd_ch),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .pkt_valid(pkt_valid), .overrun(overrun), .underrun(underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dat_a(input logic [15:0] base, input int k);
    return base + 16'(k);
  endfunction
  function automatic logic [15:0] dat_b(input logic [15:0] base, input int k);
    return (base ^ 16'h5A5A) + 16'(k);
  endfunction

  task automatic do_reset(input logic [6:0] n);
    @(negedge clk);
    rst_n = 0; n_cfg = n;
    fast_sync = 0; slow_sync = 0; res_valid = 0; rd_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // fast pulse, converter answers after lat cycles
  task automatic sample(input logic [15:0] a, input logic [15:0] b, input int lat);
    @(negedge clk); fast_sync = 1;
    @(negedge clk); fast_sync = 0;
    chk("R2 conv_start", conv_start, 1);
    repeat (lat) @(negedge clk);
    res_valid = 1; res_a = a; res_b = b;
    @(negedge clk); res_valid = 0;
  endtask

  task automatic close_cycle();
    @(negedge clk); slow_sync = 1;
    @(negedge clk); slow_sync = 0;
  endtask

  task automatic rd(input logic ch, input int idx, output logic [15:0] d);
    @(negedge clk); rd_req = 1; rd_ch = ch; rd_idx = 7'(idx);
    @(negedge clk); rd_req = 0;
    chk("R8 rd_valid", rd_valid, 1);
    d = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(7'd4);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 pkt_valid", pkt_valid, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 underrun", underrun, 0);
    rd(1'b0, 0, got); chk("R1 read zero", got, 0);

    // vector table: R4 order, R5 excess, R7 short, R10 limits
    for (int v = 0; v < NV; v++) begin
      do_reset(VN[v]);
      for (int k = 0; k < int'(VP[v]); k++)
        sample(dat_a(VB[v], k), dat_b(VB[v], k), k % 3);
      close_cycle();
      chk("R6 pkt_valid", pkt_valid, 1);
      chk("R7 underrun", underrun, (VP[v] < VN[v]) ? 1 : 0);
      chk("R3 no overrun", overrun, 0);
      for (int k = 0; k < int'(VN[v]); k++) begin
        rd(1'b0, k, got);
        chk("R4 R10 chan A", got, (k < int'(VP[v])) ? dat_a(VB[v], k) : 16'h0);
        rd(1'b1, k, got);
        chk("R4 R10 chan B", got, (k < int'(VP[v])) ? dat_b(VB[v], k) : 16'h0);
      end
      if (VN[v] < 7'd127) begin
        rd(1'b0, int'(VN[v]), got); chk("R5 R8 beyond n", got, 0);
      end
    end

    // R3 overrun: second fast pulse while pending
    do_reset(7'd2);
    @(negedge clk); fast_sync = 1;
    @(negedge clk); fast_sync = 0;
    chk("R2 first start", conv_start, 1);
    @(negedge clk); fast_sync = 1;
    @(negedge clk); fast_sync = 0;
    chk("R3 no restart", conv_start, 0);
    chk("R3 overrun set", overrun, 1);
    res_valid = 1; res_a = 16'hABCD; res_b = 16'h1234;
    @(negedge clk); res_valid = 0;
    repeat (3) @(negedge clk);
    chk("R3 overrun sticky", overrun, 1);

    // R5 stray result without pending conversion
    do_reset(7'd2);
    @(negedge clk); res_valid = 1; res_a = 16'hDEAD; res_b = 16'hBEEF;
    @(negedge clk); res_valid = 0;
    sample(16'h0101, 16'h0202, 1);
    close_cycle();
    rd(1'b0, 0, got); chk("R5 stray ignored A", got, 16'h0101);
    rd(1'b1, 0, got); chk("R5 stray ignored B", got, 16'h0202);
    rd(1'b0, 1, got); chk("R7 missing zero", got, 0);
    chk("R7 underrun set", underrun, 1);

    // R9 packet stable while next cycle fills
    do_reset(7'd3);
    for (int k = 0; k < 3; k++) sample(dat_a(16'h3000, k), dat_b(16'h3000, k), 0);
    close_cycle();
    for (int k = 0; k < 3; k++) begin
      sample(dat_a(16'h9000, k), dat_b(16'h9000, k), 1);
      rd(1'b0, k, got); chk("R9 old A stable", got, dat_a(16'h3000, k));
      rd(1'b1, 2 - k, got); chk("R9 old B stable", got, dat_b(16'h3000, 2 - k));
    end
    close_cycle();
    rd(1'b0, 2, got); chk("R6 new packet A", got, dat_a(16'h9000, 2));
    rd(1'b1, 0, got); chk("R6 new packet B", got, dat_b(16'h9000, 0));
    chk("R7 no underrun", underrun, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule